// File: doc/BRIEF.md
# DMA channel transfer sequencer

This block is the sequencing core of one channel of a two-dimensional DMA engine. A transfer is laid out as frames of elements. Each transferred element is reported by a one-cycle beat pulse. On each beat the block moves the source and destination addresses forward by a signed per-element stride. When a frame completes, it also adds a signed per-frame stride. It keeps element, frame and packet positions, and it records sticky status events: half frame, frame done, last frame begun, packet done and block done.

The channel has four synchronisation modes. A synchronised channel goes idle after each element, each frame or each packet, and waits for a request to resume. At the end of a block the channel takes one of four actions, chosen by configuration: disable itself and optionally ask for a linked channel to be enabled, disable itself, reload itself and carry on, or park until software pulses an end-program strobe. A free-running channel also keeps a 16-bit progress snapshot of the destination address. Moving the data, arbitrating between channels and decoding the register file belong to the surrounding engine.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the addresses, status, progress, enabled, active, waiting, link_req and irq outputs are all zero.
- R2: An en_strobe reloads both addresses from their start values and clears the element, frame and packet positions. It also sets enabled and active, clears waiting, and takes priority over every other input in the same cycle.
- R3: A beat counts only while active; a beat on an idle channel changes nothing. Each counted beat adds the sign-extended element stride to each address. When the element position reaches cfg_elems, it wraps to zero, the frame position increments, and each address also receives its sign-extended frame stride.
- R4: The status bits are [0] half frame, [1] frame done, [2] last frame begun, [3] packet done and [4] block done. Half frame is set when the element position after a beat equals floor(cfg_elems/2). Last frame begun is set on a frame boundary where the new frame position equals cfg_frames-1 and the block has not ended. Block done is set at the final element of frame cfg_frames-1, and only if cfg_irq_en[4] is 1.
- R5: Status bits are sticky. clr_status clears them, but events from the same cycle are still recorded. irq is high whenever any status bit is set together with its bit in cfg_irq_en.
- R6: cfg_sync selects the mode: 0 free-running, 1 element, 2 frame, 3 packet. In element mode the channel goes inactive after every beat. In frame mode it goes inactive at each frame boundary, and in packet mode at each packet boundary. A req restarts an enabled, idle channel that is not waiting.
- R7: In packet mode only, a packet position counts beats and wraps after cfg_pkt of them, setting packet done.
- R8: At block end with cfg_compat set, the channel clears enabled and active. If cfg_link_en is also set, link_req pulses for exactly one cycle.
- R9: At block end without cfg_compat: with cfg_auto clear the channel disables. With cfg_auto set and either cfg_repeat or end_prog high, it reloads as in R2 and stays active unless its sync mode idles it. Otherwise it sets waiting and goes inactive.
- R10: end_prog while waiting reloads the channel, sets active and clears waiting.
- R11: In free-running mode, a beat that ends a frame causes progress to take dst_addr[15:0] as it stands after that beat, two clock edges after the beat.
- R12: All other results appear at the clock edge that samples the stimulus; irq follows status without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_strobe | input | 1 | Enable and load the channel |
| req | input | 1 | Synchronisation request, resumes an idle channel |
| beat | input | 1 | One element transferred |
| end_prog | input | 1 | Software end-program strobe |
| clr_status | input | 1 | Clear sticky status |
| cfg_src_start | input | AW | Source start address |
| cfg_dst_start | input | AW | Destination start address |
| cfg_src_estride | input | SW | Signed source element stride |
| cfg_dst_estride | input | SW | Signed destination element stride |
| cfg_src_fstride | input | SW | Signed source frame stride |
| cfg_dst_fstride | input | SW | Signed destination frame stride |
| cfg_elems | input | EW | Elements per frame (nonzero) |
| cfg_frames | input | FW | Frames per block (nonzero) |
| cfg_pkt | input | EW | Elements per packet (nonzero) |
| cfg_sync | input | 2 | Synchronisation mode |
| cfg_compat | input | 1 | Disable-and-link behaviour at block end |
| cfg_link_en | input | 1 | Request the linked channel at block end |
| cfg_auto | input | 1 | Auto-initialise at block end |
| cfg_repeat | input | 1 | Reload without waiting for end_prog |
| cfg_irq_en | input | 5 | Per-flag interrupt enables |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| status | output | 5 | Sticky status flags |
| irq | output | 1 | Interrupt request |
| enabled | output | 1 | Channel enabled |
| active | output | 1 | Channel accepting beats |
| waiting | output | 1 | Parked for end_prog |
| link_req | output | 1 | One-cycle request to enable the linked channel |
| progress | output | 16 | Destination progress snapshot |

## Verification
Addresses, status, the three channel flags and link_req respond to a stimulus at the very next clock edge. The bench therefore drives each input at a falling edge, advances its model by one step, and compares at the following falling edge. The progress snapshot is due one edge later, so the model keeps a pending-capture flag and applies it on the following step, just as the hardware does. irq is compared at the same point as status, against the model's status masked with the enables.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SYNC_NONE  = 2'd0,
    SYNC_ELEM  = 2'd1,
    SYNC_FRAME = 2'd2,
    SYNC_PKT   = 2'd3
  } sync_mode_e;

  localparam int ST_HALF  = 0;
  localparam int ST_FRAME = 1;
  localparam int ST_LAST  = 2;
  localparam int ST_PKT   = 3;
  localparam int ST_BLOCK = 4;
  localparam int ST_W     = 5;
  localparam int PROG_W   = 16;
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          frame_end,
  input  logic [AW-1:0] start,
  input  logic [SW-1:0] estride,
  input  logic [SW-1:0] fstride,
  output logic [AW-1:0] addr
);
  localparam int EXT = AW - SW;

  logic [AW-1:0] addr_d;
  logic [AW-1:0] e_ext, f_ext;

  always_comb begin
    e_ext  = {{EXT{estride[SW-1]}}, estride};
    f_ext  = frame_end ? {{EXT{fstride[SW-1]}}, fstride} : '0;
    addr_d = addr;
    if (load)      addr_d = start;
    else if (step) addr_d = addr + e_ext + f_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addr <= '0;
    else if (load || step)  addr <= addr_d;
  end
endmodule

// File: rtl/dma_seq_pos.sv
module dma_seq_pos #(
  parameter int EW = 24,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          pkt_mode,
  input  logic [EW-1:0] cfg_elems,
  input  logic [EW-1:0] cfg_pkt,
  input  logic [FW-1:0] cfg_frames,
  output logic          ev_half,
  output logic          ev_frame,
  output logic          ev_last,
  output logic          ev_pkt,
  output logic          ev_block
);
  logic [EW-1:0] elem_q, elem_d, pkt_q, pkt_d;
  logic [FW-1:0] frm_q, frm_d;
  logic [EW:0]   e_inc, p_inc;
  logic [FW:0]   f_inc, f_last;

  always_comb begin
    e_inc    = {1'b0, elem_q} + (EW+1)'(1);
    p_inc    = {1'b0, pkt_q} + (EW+1)'(1);
    f_inc    = {1'b0, frm_q} + (FW+1)'(1);
    f_last   = {1'b0, cfg_frames} - (FW+1)'(1);
    ev_frame = step && (e_inc == {1'b0, cfg_elems});
    ev_block = ev_frame && (f_inc == {1'b0, cfg_frames});
    ev_half  = step && (e_inc == {1'b0, (cfg_elems >> 1)});
    ev_last  = ev_frame && !ev_block && (f_inc == f_last);
    ev_pkt   = step && pkt_mode && (p_inc == {1'b0, cfg_pkt});
    elem_d   = elem_q;
    frm_d    = frm_q;
    pkt_d    = pkt_q;
    if (load) begin
      elem_d = '0;
      frm_d  = '0;
      pkt_d  = '0;
    end else if (step) begin
      elem_d = ev_frame ? '0 : e_inc[EW-1:0];
      if (ev_frame) frm_d = f_inc[FW-1:0];
      if (pkt_mode) pkt_d = ev_pkt ? '0 : p_inc[EW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      frm_q  <= '0;
      pkt_q  <= '0;
    end else if (load || step) begin
      elem_q <= elem_d;
      frm_q  <= frm_d;
      pkt_q  <= pkt_d;
    end
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_strobe,
  input  logic              req,
  input  logic              beat,
  input  logic              end_prog,
  input  logic              clr_status,
  input  sync_mode_e        mode,
  input  logic              cfg_compat,
  input  logic              cfg_link_en,
  input  logic              cfg_auto,
  input  logic              cfg_repeat,
  input  logic [ST_W-1:0]   cfg_irq_en,
  input  logic              ev_half,
  input  logic              ev_frame,
  input  logic              ev_last,
  input  logic              ev_pkt,
  input  logic              ev_block,
  input  logic [PROG_W-1:0] dst_low,
  output logic              step,
  output logic              load,
  output logic [ST_W-1:0]   status,
  output logic              irq,
  output logic              enabled,
  output logic              active,
  output logic              waiting,
  output logic              link_req,
  output logic [PROG_W-1:0] progress
);
  logic            en_d, act_d, wait_d, link_d, cap_d, cap_q, sync_stop;
  logic [ST_W-1:0] st_set, st_d;

  always_comb begin
    step      = beat && active;
    sync_stop = step && ((mode == SYNC_ELEM) ||
                         (mode == SYNC_FRAME && ev_frame) || ev_pkt);
    cap_d     = ev_frame && (mode == SYNC_NONE);
    en_d      = enabled;
    act_d     = active && !sync_stop;
    wait_d    = waiting;
    link_d    = 1'b0;
    load      = 1'b0;
    if (ev_block) begin
      if (cfg_compat) begin
        en_d   = 1'b0;
        act_d  = 1'b0;
        link_d = cfg_link_en;
      end else if (!cfg_auto) begin
        en_d  = 1'b0;
        act_d = 1'b0;
      end else if (cfg_repeat || end_prog) begin
        load = 1'b1;
      end else begin
        wait_d = 1'b1;
        act_d  = 1'b0;
      end
    end
    if (waiting && end_prog) begin
      load   = 1'b1;
      wait_d = 1'b0;
      act_d  = 1'b1;
    end
    if (req && enabled && !active && !waiting) act_d = 1'b1;
    if (en_strobe) begin
      load   = 1'b1;
      en_d   = 1'b1;
      act_d  = 1'b1;
      wait_d = 1'b0;
    end
    st_set = '0;
    st_set[ST_HALF]  = ev_half;
    st_set[ST_FRAME] = ev_frame;
    st_set[ST_LAST]  = ev_last;
    st_set[ST_PKT]   = ev_pkt;
    st_set[ST_BLOCK] = ev_block && cfg_irq_en[ST_BLOCK];
    st_d = (clr_status ? '0 : status) | st_set;
    irq  = |(status & cfg_irq_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled  <= 1'b0;
      active   <= 1'b0;
      waiting  <= 1'b0;
      link_req <= 1'b0;
      status   <= '0;
      cap_q    <= 1'b0;
      progress <= '0;
    end else begin
      enabled  <= en_d;
      active   <= act_d;
      waiting  <= wait_d;
      link_req <= link_d;
      status   <= st_d;
      cap_q    <= cap_d;
      if (cap_q) progress <= dst_low;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int EW = 24,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_strobe,
  input  logic          req,
  input  logic          beat,
  input  logic          end_prog,
  input  logic          clr_status,
  input  logic [AW-1:0] cfg_src_start,
  input  logic [AW-1:0] cfg_dst_start,
  input  logic [SW-1:0] cfg_src_estride,
  input  logic [SW-1:0] cfg_dst_estride,
  input  logic [SW-1:0] cfg_src_fstride,
  input  logic [SW-1:0] cfg_dst_fstride,
  input  logic [EW-1:0] cfg_elems,
  input  logic [FW-1:0] cfg_frames,
  input  logic [EW-1:0] cfg_pkt,
  input  logic [1:0]    cfg_sync,
  input  logic          cfg_compat,
  input  logic          cfg_link_en,
  input  logic          cfg_auto,
  input  logic          cfg_repeat,
  input  logic [4:0]    cfg_irq_en,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [4:0]    status,
  output logic          irq,
  output logic          enabled,
  output logic          active,
  output logic          waiting,
  output logic          link_req,
  output logic [15:0]   progress
);
  localparam int NPORT = 2;

  sync_mode_e    mode;
  logic          step, load, pkt_mode;
  logic          ev_half, ev_frame, ev_last, ev_pkt, ev_block;
  logic [AW-1:0] start_a [NPORT];
  logic [SW-1:0] es_a    [NPORT];
  logic [SW-1:0] fs_a    [NPORT];
  logic [AW-1:0] addr_a  [NPORT];

  assign mode       = sync_mode_e'(cfg_sync);
  assign pkt_mode   = (mode == SYNC_PKT);
  assign start_a[0] = cfg_src_start;
  assign start_a[1] = cfg_dst_start;
  assign es_a[0]    = cfg_src_estride;
  assign es_a[1]    = cfg_dst_estride;
  assign fs_a[0]    = cfg_src_fstride;
  assign fs_a[1]    = cfg_dst_fstride;
  assign src_addr   = addr_a[0];
  assign dst_addr   = addr_a[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dma_seq_addr #(.AW(AW), .SW(SW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .frame_end(ev_frame), .start(start_a[g]), .estride(es_a[g]),
      .fstride(fs_a[g]), .addr(addr_a[g])
    );
  end

  dma_seq_pos #(.EW(EW), .FW(FW)) u_pos (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .pkt_mode(pkt_mode),
    .cfg_elems(cfg_elems), .cfg_pkt(cfg_pkt), .cfg_frames(cfg_frames),
    .ev_half(ev_half), .ev_frame(ev_frame), .ev_last(ev_last),
    .ev_pkt(ev_pkt), .ev_block(ev_block)
  );

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_strobe(en_strobe), .req(req), .beat(beat),
    .end_prog(end_prog), .clr_status(clr_status), .mode(mode),
    .cfg_compat(cfg_compat), .cfg_link_en(cfg_link_en), .cfg_auto(cfg_auto),
    .cfg_repeat(cfg_repeat), .cfg_irq_en(cfg_irq_en),
    .ev_half(ev_half), .ev_frame(ev_frame), .ev_last(ev_last),
    .ev_pkt(ev_pkt), .ev_block(ev_block), .dst_low(dst_addr[PROG_W-1:0]),
    .step(step), .load(load), .status(status), .irq(irq),
    .enabled(enabled), .active(active), .waiting(waiting),
    .link_req(link_req), .progress(progress)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_strobe,
  input logic          beat,
  input logic          end_prog,
  input logic          clr_status,
  input logic [1:0]    cfg_sync,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [4:0]    status,
  input logic          enabled,
  input logic          active,
  input logic          waiting,
  input logic          link_req,
  input logic [15:0]   progress
);
  // R3: addresses hold when nothing can step or reload them
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(beat && active) && !en_strobe && !(waiting && end_prog))
      |=> ($stable(src_addr) && $stable(dst_addr)));

  // R5: flags stay set until a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((status & $past(status)) == $past(status)));

  // R8: the link request lasts a single cycle
  a_r8_link_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |=> !link_req);

  // R9: a parked channel accepts no beats
  a_r9_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !active);

  // R6: activity requires the channel to be enabled
  a_r6_active_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> enabled);

  // R11: progress moves only after a free-running step
  a_r11_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_sync, 2) != 2'd0) |-> $stable(progress));
endmodule

bind dma_chan_seq dma_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_strobe(en_strobe), .beat(beat),
  .end_prog(end_prog), .clr_status(clr_status), .cfg_sync(cfg_sync),
  .src_addr(src_addr), .dst_addr(dst_addr), .status(status),
  .enabled(enabled), .active(active), .waiting(waiting),
  .link_req(link_req), .progress(progress)
);

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        en_strobe, req, beat, end_prog, clr_status;
  logic [31:0] cfg_src_start, cfg_dst_start;
  logic [15:0] cfg_src_estride, cfg_dst_estride, cfg_src_fstride, cfg_dst_fstride;
  logic [23:0] cfg_elems, cfg_pkt;
  logic [15:0] cfg_frames;
  logic [1:0]  cfg_sync;
  logic        cfg_compat, cfg_link_en, cfg_auto, cfg_repeat;
  logic [4:0]  cfg_irq_en;
  logic [31:0] src_addr, dst_addr;
  logic [4:0]  status;
  logic        irq, enabled, active, waiting, link_req;
  logic [15:0] progress;

  dma_chan_seq i_dma_chan_seq (.*);

  int    n_chk, n_bad;
  string cur_req;

  // model state
  logic [31:0] m_src, m_dst;
  int          m_e, m_f, m_p;
  logic [4:0]  m_st;
  logic        m_en, m_act, m_wait, m_link, m_cap;
  logic [15:0] m_prog;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string what, input string rq, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s/%s actual=%0h expected=%0h at %0t", rq, cur_req, what,
               act_v, exp_v, $time);
    end
  endtask

  task automatic check_all();
    chk("src", "R3", src_addr, m_src);
    chk("dst", "R3", dst_addr, m_dst);
    chk("status", "R4", {27'd0, status}, {27'd0, m_st});
    chk("irq", "R5", {31'd0, irq}, {31'd0, |(m_st & cfg_irq_en)});
    chk("active", "R6", {31'd0, active}, {31'd0, m_act});
    chk("enabled", "R2", {31'd0, enabled}, {31'd0, m_en});
    chk("waiting", "R9", {31'd0, waiting}, {31'd0, m_wait});
    chk("link", "R8", {31'd0, link_req}, {31'd0, m_link});
    chk("progress", "R11", {16'd0, progress}, {16'd0, m_prog});
  endtask

  // one clock of the reference behaviour, from the requirements
  task automatic model_step();
    logic step, evf, evb, evh, evl, evp, stop, ld, n_act, o_en, o_act, o_wait;
    int   e_inc, f_inc, p_inc;
    o_en = m_en; o_act = m_act; o_wait = m_wait;
    step  = beat && m_act;
    e_inc = m_e + 1; f_inc = m_f + 1; p_inc = m_p + 1;
    evf = step && (e_inc == int'(cfg_elems));
    evb = evf && (f_inc == int'(cfg_frames));
    evh = step && (e_inc == int'(cfg_elems) / 2);
    evl = evf && !evb && (f_inc == int'(cfg_frames) - 1);
    evp = step && (cfg_sync == 2'd3) && (p_inc == int'(cfg_pkt));
    if (m_cap) m_prog = m_dst[15:0];                   // R11 two-edge latency
    m_cap = evf && (cfg_sync == 2'd0);
    stop  = step && (cfg_sync == 2'd1 || (cfg_sync == 2'd2 && evf) || evp); // R6
    n_act = m_act && !stop;
    ld = 1'b0; m_link = 1'b0;
    m_st = (clr_status ? 5'd0 : m_st) | {evb && cfg_irq_en[4], evp, evl, evf, evh};
    if (evb) begin
      if (cfg_compat) begin m_en = 0; n_act = 0; m_link = cfg_link_en; end     // R8
      else if (!cfg_auto) begin m_en = 0; n_act = 0; end                        // R9
      else if (cfg_repeat || end_prog) ld = 1;
      else begin m_wait = 1; n_act = 0; end
    end
    if (o_wait && end_prog) begin ld = 1; m_wait = 0; n_act = 1; end           // R10
    if (req && o_en && !o_act && !o_wait) n_act = 1;
    if (en_strobe) begin ld = 1; m_en = 1; n_act = 1; m_wait = 0; end          // R2
    if (ld) begin
      m_src = cfg_src_start; m_dst = cfg_dst_start; m_e = 0; m_f = 0; m_p = 0;
    end else if (step) begin
      m_src = m_src + sx(cfg_src_estride) + (evf ? sx(cfg_src_fstride) : 32'd0);
      m_dst = m_dst + sx(cfg_dst_estride) + (evf ? sx(cfg_dst_fstride) : 32'd0);
      m_e = evf ? 0 : e_inc;
      if (evf) m_f = f_inc;
      if (cfg_sync == 2'd3) m_p = evp ? 0 : p_inc;                            // R7
    end
    m_act = n_act;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    check_all();
    en_strobe = 0; end_prog = 0; clr_status = 0; req = 0; beat = 0;
  endtask

  task automatic enable_ch();
    en_strobe = 1;
    tick();
  endtask

  task automatic drive(input int n, input int pb, input int pr, input int pe, input int pc);
    for (int i = 0; i < n; i++) begin
      beat       = ($urandom % 100) < pb;
      req        = ($urandom % 100) < pr;
      end_prog   = ($urandom % 100) < pe;
      clr_status = ($urandom % 100) < pc;
      tick();
    end
  endtask

  task automatic set_cfg(input int el, input int fr, input int pk, input int sy,
                         input bit cp, input bit ln, input bit au, input bit rp);
    cfg_elems = 24'(el); cfg_frames = 16'(fr); cfg_pkt = 24'(pk); cfg_sync = 2'(sy);
    cfg_compat = cp; cfg_link_en = ln; cfg_auto = au; cfg_repeat = rp;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk = 0; n_bad = 0; cur_req = "R1";
    rst_n = 0; en_strobe = 0; req = 0; beat = 0; end_prog = 0; clr_status = 0;
    cfg_src_start = 32'h1000_0000; cfg_dst_start = 32'h2000_fff0;
    cfg_src_estride = 16'd4; cfg_dst_estride = 16'hfffe;
    cfg_src_fstride = 16'd64; cfg_dst_fstride = 16'hffc0;
    cfg_irq_en = 5'h1f;
    set_cfg(4, 3, 3, 0, 0, 0, 0, 0);
    m_src = 0; m_dst = 0; m_e = 0; m_f = 0; m_p = 0; m_st = 0;
    m_en = 0; m_act = 0; m_wait = 0; m_link = 0; m_cap = 0; m_prog = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();                                   // R1 reset state
    cur_req = "R3"; beat = 1; tick();              // beat on idle channel ignored
    // R2 R3 R4 R11: free-running, whole block, then disable
    cur_req = "R2"; enable_ch();
    cur_req = "R11"; drive(16, 100, 0, 0, 0);
    // R5: clear while events keep arriving
    cur_req = "R5"; enable_ch(); drive(10, 100, 0, 0, 50);
    // R6: element, frame sync with requests
    cur_req = "R6"; set_cfg(3, 2, 2, 1, 0, 0, 0, 0); enable_ch(); drive(30, 80, 40, 0, 10);
    set_cfg(3, 3, 2, 2, 0, 0, 0, 0); enable_ch(); drive(30, 90, 30, 0, 10);
    // R7: packet sync
    cur_req = "R7"; set_cfg(5, 2, 3, 3, 0, 0, 0, 0); enable_ch(); drive(40, 90, 30, 0, 10);
    // R8: compat with link
    cur_req = "R8"; set_cfg(2, 2, 1, 0, 1, 1, 0, 0); enable_ch(); drive(6, 100, 0, 0, 0);
    // R9: auto repeat, then auto with wait; R4 block flag masked
    cur_req = "R9"; set_cfg(2, 2, 1, 0, 0, 0, 1, 1); cfg_irq_en = 5'h0f;
    enable_ch(); drive(12, 100, 0, 0, 0);
    set_cfg(3, 1, 1, 0, 0, 0, 1, 0); cfg_irq_en = 5'h1f; enable_ch(); drive(5, 100, 0, 0, 0);
    // R10: release the parked channel
    cur_req = "R10"; end_prog = 1; tick(); drive(6, 100, 0, 0, 0);
    // R12: random configurations and traffic
    cur_req = "R12";
    for (int k = 0; k < 60; k++) begin
      set_cfg(1 + $urandom % 6, 1 + $urandom % 4, 1 + $urandom % 5, $urandom % 4,
              $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      cfg_src_start = $urandom; cfg_dst_start = $urandom;
      cfg_src_estride = 16'($urandom); cfg_dst_estride = 16'($urandom);
      cfg_src_fstride = 16'($urandom); cfg_dst_fstride = 16'($urandom);
      cfg_irq_en = 5'($urandom);
      enable_ch();
      drive(150, 70, 30, 8, 8);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule